// File: doc/BRIEF.md
# Paged MDIO-to-Register Bridge

The bridge lets a management station that can only perform 16-bit, Clause-22 style transactions reach a file of 32-bit registers. Transactions arrive already decoded from the serial line: a 5-bit PHY address, a 5-bit register number, a read/write flag and 16 bits of write data. A page register, written through PHY 0x1F register 0x10, supplies the upper nine bits of a 16-bit word address. The low three bits of a PHY in the window 0x10..0x17 supply the next three bits. The register number with its bit 0 dropped supplies the bottom four bits. The matching byte address is the word address shifted left by two.

Each 32-bit word is split across two registers. The even register number carries bits 15:0 and the odd register number right after it carries bits 31:16. The station writes the high half first and then the low half. The high half waits in a staging register, and the whole word goes onto the internal register bus in the cycle the low half is accepted. A read takes the low half first, which captures the word, and then the high half, which is served from that capture. A small register array stands in for the real register file behind the bus.

Requests use a valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or the pending response leaves in the same cycle. Each accepted read yields exactly one response, registered and offered one cycle later. A response stays valid and unchanged until `rsp_ready` takes it. Writes yield no response.

Top module: `paged_mdio_bridge`

## Requirements
- R1: After reset the page register, the staging register, the read capture and every register-file word are zero, `rsp_valid` is low and `req_ready` is high.
- R2: A write to PHY 0x1F register 0x10 loads the page register with write-data bits 8:0. A read of that location returns the page zero-extended to 16 bits.
- R3: For PHY addresses 0x10..0x17 the word address is {page[8:0], phy[2:0], reg[4:1]}, so every PHY/register pair in the window reaches a distinct word.
- R4: A write to an odd register number in the window only loads the staging register. The register file is unchanged until a later even-register write.
- R5: A write to an even register number in the window commits {staging, write data} to the addressed word. The commit happens in the cycle of acceptance, so the next request sees it. The staging register keeps its value after the commit.
- R6: A read of an even register returns bits 15:0 of the word and captures bits 31:16. A read of an odd register returns the last capture, even if the word was written in between.
- R7: Accesses to PHY addresses 0x00..0x0F and 0x18..0x1E, and to PHY 0x1F at any register other than 0x10, change no state. Reads of them return 0xFFFF.
- R8: A request is accepted when `req_valid` and `req_ready` are both high, with `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted read gives one response on the following cycle, writes give none, and a response is held stable while `rsp_ready` is low.
- R9: Word addresses at or above the register-file depth (64 words by default) drop writes and read as zero. No other word is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_phy | input | 5 | Decoded PHY address |
| req_reg | input | 5 | Decoded register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Station takes the response |
| rsp_data | output | 16 | Read data |

## Verification
The bench issues a high-half write with no low half, then reads the word. A design that commits on the high half would return the new upper bits. It commits twice from a single staged high half, which catches a staging register that clears after each use. It writes the word between the low and high reads, so a design that re-reads the array for the high half would return the new bits instead of the captured ones. It writes through PHY 0x00, PHY 0x1F register 0x11 and a page beyond the array, then reads back word 0 and the page. A decoder that trusts only the low address bits would alias those writes onto real words. Responses are also throttled, which catches a response that changes or is lost under back-pressure.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  parameter int DATA_W     = 16;
  parameter int PHY_W      = 5;
  parameter int REGN_W     = 5;
  parameter int PAGE_W     = 9;
  parameter int PHY_SEL_W  = 3;
  parameter int WORD_W     = 2 * DATA_W;
  parameter int WADDR_W    = PAGE_W + PHY_SEL_W + REGN_W - 1;
  parameter logic [PHY_W-1:0]  PAGE_PHY = 5'h1F;
  parameter logic [REGN_W-1:0] PAGE_REG = 5'h10;
  parameter logic [1:0]        WIN_TOP  = 2'b10;

  typedef enum logic [1:0] {
    ACC_IGNORE = 2'd0,
    ACC_PAGE   = 2'd1,
    ACC_LOW    = 2'd2,
    ACC_HIGH   = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/mdio_page_decode.sv
module mdio_page_decode
  import mdio_bridge_pkg::*;
(
  input  logic [PHY_W-1:0]   phy,
  input  logic [REGN_W-1:0]  regn,
  input  logic [PAGE_W-1:0]  page,
  output acc_kind_t          kind,
  output logic [WADDR_W-1:0] waddr
);
  always_comb begin
    if (phy == PAGE_PHY && regn == PAGE_REG)
      kind = ACC_PAGE;
    else if (phy[PHY_W-1:PHY_SEL_W] == WIN_TOP)
      kind = regn[0] ? ACC_HIGH : ACC_LOW;
    else
      kind = ACC_IGNORE;
  end

  assign waddr = {page, phy[PHY_SEL_W-1:0], regn[REGN_W-1:1]};
endmodule

// File: rtl/mdio_half_stager.sv
module mdio_half_stager
  import mdio_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              is_write,
  input  acc_kind_t         kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [PAGE_W-1:0] page,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_half
);
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] snap_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page      <= '0;
      stage_q   <= '0;
      snap_hi_q <= '0;
    end else if (acc) begin
      unique case (kind)
        ACC_PAGE: if (is_write)  page      <= wdata[PAGE_W-1:0];
        ACC_HIGH: if (is_write)  stage_q   <= wdata;
        ACC_LOW:  if (!is_write) snap_hi_q <= rf_rdata[WORD_W-1:DATA_W];
        default: ;
      endcase
    end
  end

  assign bus_we    = acc && is_write && (kind == ACC_LOW);
  assign bus_wdata = {stage_q, wdata};

  always_comb begin
    unique case (kind)
      ACC_PAGE: rd_half = DATA_W'(page);
      ACC_LOW:  rd_half = rf_rdata[DATA_W-1:0];
      ACC_HIGH: rd_half = snap_hi_q;
      default:  rd_half = '1;
    endcase
  end

  AST_STAGE_ONLY_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && is_write && kind == ACC_HIGH) |=> $stable(stage_q)); // R4

  AST_PAGE_ONLY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && is_write && kind == ACC_PAGE) |=> $stable(page)); // R2
endmodule

// File: rtl/mdio_reg_file_model.sv
module mdio_reg_file_model
  import mdio_bridge_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] addr,
  input  logic               we,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORD_W-1:0] mem [WORDS];
  logic              in_range;

  assign in_range = (32'(addr) < WORDS);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && in_range && addr[IDX_W-1:0] == IDX_W'(g))
        mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (in_range && addr[IDX_W-1:0] == IDX_W'(i))
        rdata = mem[i];
  end

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> rdata == '0); // R9
endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int RF_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic        req_write,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data
);
  acc_kind_t          kind;
  logic [WADDR_W-1:0] waddr;
  logic [PAGE_W-1:0]  page;
  logic               acc;
  logic               bus_we;
  logic [WORD_W-1:0]  bus_wdata;
  logic [WORD_W-1:0]  rf_rdata;
  logic [DATA_W-1:0]  rd_half;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  mdio_page_decode u_decode (
    .phy   (req_phy),
    .regn  (req_reg),
    .page  (page),
    .kind  (kind),
    .waddr (waddr)
  );

  mdio_half_stager u_stager (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .is_write  (req_write),
    .kind      (kind),
    .wdata     (req_wdata),
    .rf_rdata  (rf_rdata),
    .page      (page),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rd_half   (rd_half)
  );

  mdio_reg_file_model #(.WORDS(RF_WORDS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (waddr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_half;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R8

  AST_COMMIT_ON_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> req_valid && req_ready && req_write && !req_reg[0]
               && req_phy[4:3] == 2'b10); // R5

  AST_OUTSIDE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_phy[4:3] != 2'b10
      && !(req_phy == 5'h1F && req_reg == 5'h10)
    |=> rsp_valid && rsp_data == 16'hFFFF); // R7
endmodule

// File: tb/paged_mdio_bridge_tb.sv
module paged_mdio_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;

  int tests = 0;
  int fails = 0;
  bit bp_en = 1'b0;
  int bp_cnt = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] model [64];
  logic [8:0]  page_m = '0;
  logic [15:0] stage_m = '0;
  logic [15:0] snap_m = '0;

  always #5 clk = ~clk;

  paged_mdio_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_phy(req_phy), .req_reg(req_reg),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    bp_cnt++;
    rsp_ready = !bp_en || (bp_cnt % 3 != 0);
  end

  // monitor / scoreboard
  logic        hold_pend = 1'b0;
  logic [15:0] hold_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(rsp_valid && rsp_data == hold_val, "R8 held response",
              {15'd0, rsp_valid, rsp_data}, {16'd1, hold_val});
      hold_pend = rsp_valid && !rsp_ready;
      hold_val  = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R8 unexpected response", 32'(rsp_data), 32'hx);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data === e, t, 32'(rsp_data), 32'(e));
        end
      end
    end
  end

  task automatic drive(input logic [4:0] phy, input logic [4:0] rg,
                       input logic wr, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_phy = phy; req_reg = rg; req_write = wr; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr_half(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d);
    logic [15:0] wa;
    if (phy == 5'h1F && rg == 5'h10) page_m = d[8:0];
    else if (phy[4:3] == 2'b10) begin
      if (rg[0]) stage_m = d;
      else begin
        wa = {page_m, phy[2:0], rg[4:1]};
        if (wa < 16'd64) model[wa[5:0]] = {stage_m, d};
      end
    end
    drive(phy, rg, 1'b1, d);
  endtask

  task automatic rd_half(input logic [4:0] phy, input logic [4:0] rg,
                         input string tag);
    logic [15:0] wa;
    logic [31:0] v;
    logic [15:0] e;
    if (phy == 5'h1F && rg == 5'h10) e = {7'd0, page_m};
    else if (phy[4:3] == 2'b10) begin
      if (rg[0]) e = snap_m;
      else begin
        wa = {page_m, phy[2:0], rg[4:1]};
        v = (wa < 16'd64) ? model[wa[5:0]] : 32'd0;
        snap_m = v[31:16];
        e = v[15:0];
      end
    end else e = 16'hFFFF;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    drive(phy, rg, 1'b0, 16'h0);
  endtask

  task automatic write32(input logic [15:0] wa, input logic [31:0] val);
    wr_half(5'h1F, 5'h10, {7'd0, wa[15:7]});
    wr_half({2'b10, wa[6:4]}, {wa[3:0], 1'b1}, val[31:16]);
    wr_half({2'b10, wa[6:4]}, {wa[3:0], 1'b0}, val[15:0]);
  endtask

  task automatic read32(input logic [15:0] wa, input string tag);
    wr_half(5'h1F, 5'h10, {7'd0, wa[15:7]});
    rd_half({2'b10, wa[6:4]}, {wa[3:0], 1'b0}, tag);
    rd_half({2'b10, wa[6:4]}, {wa[3:0], 1'b1}, tag);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(req_ready, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    rd_half(5'h1F, 5'h10, "R1 page zero");
    read32(16'h0000, "R1 word zero");
    rd_half(5'h10, 5'h03, "R1 capture zero");

    // R2 page select
    wr_half(5'h1F, 5'h10, 16'hFE5A);
    rd_half(5'h1F, 5'h10, "R2 page readback");
    wr_half(5'h1F, 5'h10, 16'h0000);

    // R3 / R5 distinct words across window
    write32(16'h0000, 32'hA1B2C3D4);
    write32(16'h003F, 32'h11223344);
    write32(16'h0010, 32'h55667788);
    write32(16'h0021, 32'h99AABBCC);
    read32(16'h0000, "R3 word 0x00");
    read32(16'h003F, "R3 word 0x3F");
    read32(16'h0010, "R5 word 0x10");
    read32(16'h0021, "R5 word 0x21");

    // R4 high half alone does not commit
    wr_half(5'h10, 5'h0B, 16'hDEAD);
    read32(16'h0005, "R4 no commit on high half");
    // R5 staging persists across two commits
    wr_half(5'h10, 5'h0A, 16'h0001);
    wr_half(5'h10, 5'h0C, 16'h0002);
    read32(16'h0005, "R5 commit word 5");
    read32(16'h0006, "R5 staged reuse word 6");

    // R6 capture survives an intervening write
    rd_half(5'h10, 5'h06, "R6 low half word 3");
    wr_half(5'h10, 5'h07, 16'h7777);
    wr_half(5'h10, 5'h06, 16'h8888);
    rd_half(5'h10, 5'h07, "R6 captured high half");
    read32(16'h0003, "R6 new word 3");

    // R7 outside window
    wr_half(5'h00, 5'h00, 16'hBEEF);
    wr_half(5'h18, 5'h01, 16'hBEEF);
    wr_half(5'h1F, 5'h11, 16'h01FF);
    rd_half(5'h00, 5'h00, "R7 phy 0x00 read");
    rd_half(5'h1E, 5'h10, "R7 phy 0x1E read");
    rd_half(5'h1F, 5'h11, "R7 phy 0x1F other reg");
    rd_half(5'h1F, 5'h10, "R7 page unchanged");
    read32(16'h0000, "R7 word 0 unchanged");

    // R9 beyond array
    write32(16'h0080, 32'hCAFEF00D);
    read32(16'h0080, "R9 out-of-range reads zero");
    read32(16'h0000, "R9 no alias onto word 0");

    // R8 back-pressure
    bp_en = 1'b1;
    read32(16'h003F, "R8 throttled word 0x3F");
    read32(16'h0021, "R8 throttled word 0x21");
    rd_half(5'h1F, 5'h10, "R8 throttled page");
    bp_en = 1'b0;

    for (int k = 0; k < 100 && exp_q.size() != 0; k++) @(posedge clk);
    check(exp_q.size() == 0, "R8 all responses seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule